// File: doc/BRIEF.md
# Burst Column Address Order Generator

This block expands one burst request into the column addresses of each beat of a memory read or write burst. A request is a start strobe with a column address, a burst length code and an ordering bit. From the next clock on, the block emits one column address per cycle, with a valid flag and a flag on the final beat.

The low bits of the column that index inside the burst follow either a wrapping count or an XOR pattern, and never leave the aligned block that holds the start column. The bits above the burst field are copied unchanged to every beat. A new request that arrives on the final beat chains straight into the next burst, so a controller can keep the address stream busy without gaps.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: A start seen at a clock edge while idle, with a legal length code, makes the first beat appear in the cycle after that edge: `valid_o` high and `col_o` equal to the start column. The remaining beats follow on consecutive cycles with `valid_o` held high.
- R3: Length code 1, 2 and 3 give bursts of 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` drops after it unless a new burst is chained.
- R4: With `btype_i` = 0 (wrapping order), the low bits of beat k equal (start low bits + k) modulo the burst length. For example, length 8 from 5 gives 5,6,7,0,1,2,3,4, and length 4 from 3 gives 3,0,1,2.
- R5: With `btype_i` = 1 (XOR order), the low bits of beat k equal the start low bits XOR k. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2, and length 4 from 3 gives 3,2,1,0.
- R6: Column bits at and above bit log2(length) equal those of the start column on every beat. Reaching the block edge wraps the low bits and never carries into the upper bits.
- R7: A start during any beat other than the final one is ignored. The running burst's addresses, length and end are unchanged.
- R8: A start with a legal code on the final beat begins the new burst in the next cycle with no idle gap.
- R9: A start with length code 0 is ignored: no beat is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe |
| col_i | input | COL_W (12) | Start column address |
| blen_i | input | 2 | Length code: 1=2, 2=4, 3=8 beats, 0 illegal |
| btype_i | input | 1 | Order: 0 wrapping count, 1 XOR |
| col_o | output | COL_W (12) | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Current beat is the final one |

## Verification
The assertions assume that the request inputs are settled at each clock edge. They also assume that the column, code and order bits mean something only in a cycle where a start is accepted, so the checker records them only then. The bench changes inputs only on falling edges and holds each strobe for exactly one cycle. It drives mid-burst and last-beat strobes on purpose, to exercise both the ignored path and the chained path.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int OFS_W  = 3;
    localparam int CODE_W = 2;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        ofs_t   start_ofs;
        ofs_t   mask;
        order_e ord;
    } burst_cfg_t;

    // mask of the in-burst index bits for a length code
    function automatic ofs_t code_to_mask(code_t c);
        ofs_t m;
        m = '0;
        for (int i = 0; i < OFS_W; i++) begin
            if (i < int'(c)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic code_valid(code_t c);
        return (c != '0) && (int'(c) <= OFS_W);
    endfunction

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  code_t      code_i,
    input  order_e     ord_i,
    input  ofs_t       start_ofs_i,
    output logic       accept_o,
    output logic       active_o,
    output logic       last_o,
    output ofs_t       beat_o,
    output burst_cfg_t cfg_o
);

    logic       active_q;
    ofs_t       beat_q;
    burst_cfg_t cfg_q;
    logic       at_end;

    assign at_end   = active_q && (beat_q == cfg_q.mask);
    assign accept_o = start_i && code_valid(code_i) && (!active_q || at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            cfg_q    <= '{start_ofs: '0, mask: '0, ord: ORD_SEQ};
        end else if (accept_o) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            cfg_q    <= '{start_ofs: start_ofs_i,
                          mask:      code_to_mask(code_i),
                          ord:       ord_i};
        end else if (at_end) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (active_q) begin
            beat_q   <= beat_q + 1'b1;
        end
    end

    assign active_o = active_q;
    assign last_o   = at_end;
    assign beat_o   = beat_q;
    assign cfg_o    = cfg_q;

endmodule

// File: rtl/burst_ofs_unit.sv
module burst_ofs_unit
    import burst_pkg::*;
(
    input  burst_cfg_t cfg_i,
    input  ofs_t       beat_i,
    output ofs_t       ofs_o
);

    ofs_t wrap_ofs;
    ofs_t xor_ofs;
    ofs_t pick;

    always_comb begin
        wrap_ofs = cfg_i.start_ofs + beat_i;
        xor_ofs  = cfg_i.start_ofs ^ beat_i;
        pick     = (cfg_i.ord == ORD_ILV) ? xor_ofs : wrap_ofs;
        ofs_o    = pick & cfg_i.mask;
    end

endmodule

// File: rtl/burst_col_merge.sv
module burst_col_merge
    import burst_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic [COL_W-1:0] base_i,
    input  ofs_t             ofs_i,
    input  ofs_t             mask_i,
    output logic [COL_W-1:0] col_o
);

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < OFS_W) begin : g_low
            assign col_o[i] = mask_i[i] ? ofs_i[i] : base_i[i];
        end else begin : g_high
            assign col_o[i] = base_i[i];
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [CODE_W-1:0] blen_i,
    input  logic              btype_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);

    logic             accept;
    logic [COL_W-1:0] base_q;
    ofs_t             beat;
    ofs_t             ofs;
    burst_cfg_t       cfg;

    always_ff @(posedge clk) begin
        if (rst)         base_q <= '0;
        else if (accept) base_q <= col_i;
    end

    burst_beat_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .code_i      (blen_i),
        .ord_i       (order_e'(btype_i)),
        .start_ofs_i (col_i[OFS_W-1:0]),
        .accept_o    (accept),
        .active_o    (valid_o),
        .last_o      (last_o),
        .beat_o      (beat),
        .cfg_o       (cfg)
    );

    burst_ofs_unit u_ofs (
        .cfg_i  (cfg),
        .beat_i (beat),
        .ofs_o  (ofs)
    );

    burst_col_merge #(.COL_W(COL_W)) u_merge (
        .base_i (base_q),
        .ofs_i  (ofs),
        .mask_i (cfg.mask),
        .col_o  (col_o)
    );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_pkg::*;
#(
    parameter int COL_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [COL_W-1:0]  col_i,
    input logic [CODE_W-1:0] blen_i,
    input logic              btype_i,
    input logic [COL_W-1:0]  col_o,
    input logic              valid_o,
    input logic              last_o
);

    logic take;
    ofs_t c_mask;
    ofs_t c_first;
    ofs_t c_cnt;
    logic c_ilv;

    assign take = start_i && code_valid(blen_i) && (!valid_o || last_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            c_mask  <= '0;
            c_first <= '0;
            c_cnt   <= '0;
            c_ilv   <= 1'b0;
        end else if (take) begin
            c_mask  <= code_to_mask(blen_i);
            c_first <= col_i[OFS_W-1:0];
            c_cnt   <= '0;
            c_ilv   <= btype_i;
        end else if (valid_o) begin
            c_cnt   <= c_cnt + 1'b1;
        end
    end

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);                                            // R3

    AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (last_o == (c_cnt == c_mask)));                     // R3

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o) |=> valid_o);                              // R2

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
        take |=> (valid_o && col_o == $past(col_i)));                   // R8

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o) |=>
            (col_o[COL_W-1:OFS_W] == $past(col_o[COL_W-1:OFS_W])));     // R6

    AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !c_ilv) |->
            (((col_o[OFS_W-1:0] ^ (c_first + c_cnt)) & c_mask) == '0)); // R4

    AST_XOR_ORDER: assert property (@(posedge clk) disable iff (rst)
        (valid_o && c_ilv) |->
            (((col_o[OFS_W-1:0] ^ c_first ^ c_cnt) & c_mask) == '0));   // R5

    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && start_i && !code_valid(blen_i)) |=> !valid_o);     // R9

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .col_i   (col_i),
    .blen_i  (blen_i),
    .btype_i (btype_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] col = '0;
    logic [1:0]  blen = '0;
    logic        btype = 1'b0;
    logic [11:0] col_o;
    logic        valid_o;
    logic        last_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_col_gen u0 (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .col_i   (col),
        .blen_i  (blen),
        .btype_i (btype),
        .col_o   (col_o),
        .valid_o (valid_o),
        .last_o  (last_o)
    );

    function automatic logic [11:0] exp_col(logic [11:0] c, logic [1:0] code,
                                            logic t, int k);
        logic [11:0] m;
        logic [11:0] lo;
        m  = (12'd1 << code) - 12'd1;
        lo = t ? ((c & m) ^ 12'(k)) : (((c & m) + 12'(k)) & m);
        return (c & ~m) | (lo & m);
    endfunction

    task automatic check_beat(logic ev, logic el, logic [11:0] ec, string tag);
        checks++;
        if (valid_o !== ev || last_o !== el || (ev && col_o !== ec)) begin
            errors++;
            $display("FAIL %s: got valid=%0b last=%0b col=%h, expected valid=%0b last=%0b col=%h",
                     tag, valid_o, last_o, col_o, ev, el, ec);
        end
    endtask

    task automatic drive_start(logic [11:0] c, logic [1:0] code, logic t);
        @(negedge clk);
        start = 1'b1; col = c; blen = code; btype = t;
        @(negedge clk);
        start = 1'b0;
    endtask

    // checks every beat; optional strobe injected while beat inj_at is shown
    task automatic walk(logic [11:0] c, logic [1:0] code, logic t, int inj_at,
                        logic [11:0] nc, logic [1:0] ncode, logic nt, string tag);
        int n;
        n = 1 << code;
        for (int k = 0; k < n; k++) begin
            if (k == inj_at) begin
                start = 1'b1; col = nc; blen = ncode; btype = nt;
            end
            check_beat(1'b1, k == n - 1, exp_col(c, code, t, k), tag);
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic idle_check(string tag);
        check_beat(1'b0, 1'b0, '0, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        idle_check("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1 after reset");
    endtask

    task automatic t_wrap8();   // R2 R4: 5,6,7,0,1,2,3,4
        drive_start(12'h125, 2'd3, 1'b0);
        walk(12'h125, 2'd3, 1'b0, -1, '0, '0, 1'b0, "R2 R4 wrap len8");
        idle_check("R3 end len8");
    endtask

    task automatic t_xor8();    // R5: 5,4,7,6,1,0,3,2
        drive_start(12'h125, 2'd3, 1'b1);
        walk(12'h125, 2'd3, 1'b1, -1, '0, '0, 1'b0, "R5 xor len8");
        idle_check("R3 end xor len8");
    endtask

    task automatic t_len4();    // R3 R4 R5: 3,0,1,2 and 3,2,1,0
        drive_start(12'h003, 2'd2, 1'b0);
        walk(12'h003, 2'd2, 1'b0, -1, '0, '0, 1'b0, "R4 wrap len4");
        idle_check("R3 end len4");
        drive_start(12'h003, 2'd2, 1'b1);
        walk(12'h003, 2'd2, 1'b1, -1, '0, '0, 1'b0, "R5 xor len4");
        idle_check("R3 end xor len4");
    endtask

    task automatic t_len2();
        drive_start(12'h7A1, 2'd1, 1'b0);
        walk(12'h7A1, 2'd1, 1'b0, -1, '0, '0, 1'b0, "R3 wrap len2");
        idle_check("R3 end len2");
        drive_start(12'h7A1, 2'd1, 1'b1);
        walk(12'h7A1, 2'd1, 1'b1, -1, '0, '0, 1'b0, "R3 xor len2");
        idle_check("R3 end xor len2");
    endtask

    task automatic t_edge();    // R6: FFF,FF8..FFE and FFE,FFF,FFC,FFD
        drive_start(12'hFFF, 2'd3, 1'b0);
        walk(12'hFFF, 2'd3, 1'b0, -1, '0, '0, 1'b0, "R6 top edge len8");
        idle_check("R6 end len8");
        drive_start(12'hFFE, 2'd2, 1'b0);
        walk(12'hFFE, 2'd2, 1'b0, -1, '0, '0, 1'b0, "R6 top edge len4");
        idle_check("R6 end len4");
    endtask

    task automatic t_mid_start();
        drive_start(12'h040, 2'd3, 1'b0);
        walk(12'h040, 2'd3, 1'b0, 3, 12'h999, 2'd1, 1'b1, "R7 mid start ignored");
        idle_check("R7 no extra burst");
    endtask

    task automatic t_chain();
        drive_start(12'h506, 2'd2, 1'b1);
        walk(12'h506, 2'd2, 1'b1, 3, 12'h2C7, 2'd3, 1'b0, "R8 first of chain");
        walk(12'h2C7, 2'd3, 1'b0, -1, '0, '0, 1'b0, "R8 chained burst");
        idle_check("R8 end of chain");
    endtask

    task automatic t_bad_code();
        drive_start(12'h123, 2'd0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            idle_check("R9 code 0 ignored");
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap8();
        t_xor8();
        t_len4();
        t_len2();
        t_edge();
        t_mid_start();
        t_chain();
        t_bad_code();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule